// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a pulse-width modulated signal. Its time base is an 8-bit period timer with two low-order sub-step bits appended, which gives 10 bits of duty resolution. Each timer increment takes four sub-steps. Each sub-step lasts 1, 4 or 16 clocks, set by a prescaler selection. When the timer reaches the programmed period at the last sub-step, the period ends. At that point the timer restarts, the output goes high, and the programmed duty is copied into a shadow register. The output falls when the time base reaches the shadow duty. Software can therefore rewrite the duty at any time without corrupting the pulse in progress.

Configuration arrives through a plain register write port. Address 0 holds the period. Address 1 holds the upper 8 duty bits. Address 2 is the control register, which holds the lower 2 duty bits, the mode field and the prescaler select. Address 3 maps to the shadow, which software can only read, so writes to it are dropped. The active shadow duty appears on a read-back port. All pins are control or status signals. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `dbuf_pwm`

## Requirements
- R1: After reset, pwm_out is 0, pwm_oe is 0, shadow_rd is 0, and all registers and the timer are cleared.
- R2: While running, a period lasts 4*(P+1)*S clocks, where P is the period register and S is the prescaler ratio. The output goes high at the period boundary. The first period after enabling stays low because the shadow duty is still zero.
- R3: With shadow duty D, where 0 < D < 4*(P+1), pwm_out is high for exactly D*S clocks from the start of each period.
- R4: The 10-bit duty is formed from write address 1, which supplies bits 9:2, and control register bits 5:4, which supply bits 1:0.
- R5: A duty write does not change the pulse in progress. The shadow copy takes the written value at the next period boundary.
- R6: A shadow duty of 0 keeps pwm_out low for the whole period. A shadow duty of at least 4*(P+1) keeps it high for the whole period.
- R7: Control bits 1:0 select the prescaler ratio: 00 gives 1, 01 gives 4, and 10 or 11 gives 16.
- R8: The block runs only while control bits 3:2 equal 11. Otherwise pwm_oe and pwm_out are 0 and the timer is held at zero. Writing 0 to the control register releases the output from the clock edge of the write onward.
- R9: shadow_rd shows the active shadow duty while running and 0 otherwise. Writes to address 3 change nothing.
- R10: A write with wr_en high at address 0, 1 or 2 takes effect at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | Modulated output |
| pwm_oe | output | 1 | Output enable, high while running |
| shadow_rd | output | 10 | Active shadow duty read-back |

## Verification
The scoreboard predicts pwm_out, pwm_oe and shadow_rd for every clock, across several periods at each prescaler ratio. The stimulus includes a duty rewritten in the middle of a period. A design without true double buffering would change the current pulse width instead of the next one. The stimulus also covers duties of zero and duties above the period span. Getting these edges wrong shows up as a one-clock glitch at the period start, or as a falling edge that never arrives in a period that should stay high. The stimulus also covers disabling the block and re-enabling it, and writes to the read-only shadow address. A stale shadow or a timer that is not restarted would shift every later edge.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int TMR_W   = 8;
  localparam int EXT_W   = 2;
  localparam int DUTY_W  = TMR_W + EXT_W;
  localparam int DIV_W   = 4;
  localparam int CTL_LO  = 4;  // duty low bits position in control
  localparam int CTL_MD  = 2;  // mode field position
  localparam logic [1:0] ADDR_PER = 2'd0;
  localparam logic [1:0] ADDR_DHI = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
  localparam logic [1:0] MODE_RUN = 2'b11;

  function automatic logic [DIV_W-1:0] psc_last(input logic [1:0] sel);
    case (sel)
      2'b00:   psc_last = DIV_W'(0);
      2'b01:   psc_last = DIV_W'(3);
      default: psc_last = DIV_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int TW = TMR_W,
  parameter int EW = EXT_W,
  localparam int BW = TW + EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    psel,
  input  logic [TW-1:0] period,
  output logic [BW-1:0] base,
  output logic [BW-1:0] base_nxt,
  output logic          tick,
  output logic          wrap
);
  logic [DIV_W-1:0] div_q;
  logic [TW-1:0]    tmr_q;
  logic [EW-1:0]    ext_q;

  assign base     = {tmr_q, ext_q};
  assign tick     = en && (div_q >= psc_last(psel));
  assign wrap     = tick && (&ext_q) && (tmr_q == period);
  assign base_nxt = wrap ? '0 : base + BW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tmr_q <= '0;
      ext_q <= '0;
    end else if (!en) begin
      div_q <= '0;
      tmr_q <= '0;
      ext_q <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + DIV_W'(1);
      if (tick) {tmr_q, ext_q} <= base_nxt;
    end
  end

  p_hold_between_ticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(base));
  p_off_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (base == '0));
  p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (base == '0));
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] duty_in,
  output logic [W-1:0] shadow
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shadow <= '0;
    else if (!en)   shadow <= '0;
    else if (load)  shadow <= duty_in;
  end

  p_hold_mid_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> $stable(shadow));
  p_load_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (shadow == $past(duty_in)));
endmodule

// File: rtl/dbuf_pwm.sv
module dbuf_pwm
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [TMR_W-1:0]  wr_data,
  output logic              pwm_out,
  output logic              pwm_oe,
  output logic [DUTY_W-1:0] shadow_rd
);
  logic [TMR_W-1:0]  period_q, duty_hi_q, ctrl_q;
  logic [DUTY_W-1:0] duty_w, shadow, base, base_nxt;
  logic              pwm_on, tick, wrap, out_q;

  // register write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q  <= '0;
      duty_hi_q <= '0;
      ctrl_q    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_PER: period_q  <= wr_data;
        ADDR_DHI: duty_hi_q <= wr_data;
        ADDR_CTL: ctrl_q    <= wr_data;
        default:  ;  // shadow address is read-only
      endcase
    end
  end

  assign duty_w = {duty_hi_q, ctrl_q[CTL_LO +: EXT_W]};
  assign pwm_on = (ctrl_q[CTL_MD +: 2] == MODE_RUN);

  pwm_timebase #(.TW(TMR_W), .EW(EXT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(pwm_on), .psel(ctrl_q[1:0]),
    .period(period_q), .base(base), .base_nxt(base_nxt),
    .tick(tick), .wrap(wrap)
  );

  pwm_shadow #(.W(DUTY_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .en(pwm_on), .load(wrap),
    .duty_in(duty_w), .shadow(shadow)
  );

  // set/reset output latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            out_q <= 1'b0;
    else if (!pwm_on)                      out_q <= 1'b0;
    else if (wrap)                         out_q <= (duty_w != '0);
    else if (tick && base_nxt == shadow)   out_q <= 1'b0;
  end

  assign pwm_out   = out_q & pwm_on;
  assign pwm_oe    = pwm_on;
  assign shadow_rd = pwm_on ? shadow : '0;

  p_rise_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(wrap));
  p_zero_duty_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow == '0) |-> !out_q);
  p_fall_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |-> ($past(base_nxt) == $past(shadow) || !$past(pwm_on) || $past(wrap)));
endmodule

// File: tb/sim_dbuf_pwm.sv
module sim_dbuf_pwm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic pwm_out, pwm_oe;
  logic [9:0] shadow_rd;

  always #2 clk = ~clk;  // 250 MHz

  dbuf_pwm u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
               .wr_data(wr_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
               .shadow_rd(shadow_rd));

  int tests = 0, fails = 0;
  logic [11:0] expq[$];  // {oe, pwm, shadow}

  // requirement-level model
  bit  m_on = 0;
  int  m_n = 0, m_act = 0, m_duty = 0, m_pr = 0, m_p = 1;
  logic [7:0] m_hi = 0, m_ctl = 0;

  function automatic int ratio(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : 16;
  endfunction

  task automatic drive(input bit we, input logic [1:0] a, input logic [7:0] d);
    bit e_pwm;
    int t;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    e_pwm = 0;
    if (m_on) begin
      m_n++;
      t = 4 * (m_pr + 1) * m_p;
      if (m_n % t == 0) m_act = m_duty;
      e_pwm = (m_n >= t) && (m_act != 0) && ((m_n % t) < m_act * m_p);
    end
    if (we) begin
      if (a == 2'd0) m_pr = d;
      if (a == 2'd1) m_hi = d;
      if (a == 2'd2) m_ctl = d;
      m_duty = {m_hi, m_ctl[5:4]};
      if (a == 2'd2) begin
        if (m_ctl[3:2] == 2'b11 && !m_on) begin
          m_on = 1; m_n = 0; m_act = 0; m_p = ratio(m_ctl[1:0]); e_pwm = 0;
        end else if (m_ctl[3:2] != 2'b11) begin
          m_on = 0; m_act = 0; e_pwm = 0;
        end
      end
    end
    expq.push_back({m_on, e_pwm, m_on ? 10'(m_act) : 10'd0});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 2'd0, 8'd0);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // monitor
  initial begin
    logic [11:0] e;
    forever begin
      @(posedge clk); #1;
      if (expq.size() > 0) begin
        e = expq.pop_front();
        chk(pwm_oe == e[11], "R8 oe", pwm_oe, e[11]);
        chk(pwm_out == e[10], "R3 pwm_out", pwm_out, e[10]);
        chk(shadow_rd == e[9:0], "R9 shadow_rd", shadow_rd, e[9:0]);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1;
    chk(pwm_out == 0, "R1 pwm_out", pwm_out, 0);
    chk(pwm_oe == 0, "R1 oe", pwm_oe, 0);
    chk(shadow_rd == 0, "R1 shadow", shadow_rd, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 R4: period 3, duty {1,2}=6, prescale 1 (R2 R3)
    drive(1, 2'd0, 8'd3);
    drive(1, 2'd1, 8'd1);
    drive(1, 2'd2, 8'h2C);
    idle(40);
    // R5: mid-period duty change to 10
    drive(1, 2'd1, 8'd2);
    idle(30);
    // R9: write to read-only shadow address ignored
    drive(1, 2'd3, 8'hFF);
    idle(20);
    // R6: duty zero
    drive(1, 2'd1, 8'd0);
    drive(1, 2'd2, 8'h0C);
    idle(40);
    // R6: duty above span
    drive(1, 2'd1, 8'hFF);
    idle(40);
    // R8: release
    drive(1, 2'd2, 8'h00);
    idle(10);
    // R7: prescale 4, period 1, duty 3
    drive(1, 2'd0, 8'd1);
    drive(1, 2'd1, 8'd0);
    drive(1, 2'd2, 8'h3D);
    idle(100);
    drive(1, 2'd2, 8'h00);
    idle(2);
    // R7: prescale 16, period 0, duty 2
    drive(1, 2'd0, 8'd0);
    drive(1, 2'd2, 8'h2E);
    idle(200);
    drive(1, 2'd2, 8'h00);
    idle(3);
    repeat (3) @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule